// File: doc/BRIEF.md
# Resumable Memory Zeroization Controller

This block sequences the erasure of a set of on-chip storage regions and proves the result. A run starts on a high level at a dedicated zeroize input, or on a command with a fixed code that arrives over a serial debug or host-slave port. The controller first records a "run in progress" flag, together with the chosen erase mode, in an external nonvolatile store. It then walks the region descriptors. For each region the mode selects, it writes zero to every word and reads every word back to check it.

Each read-back word is folded into a running digest. When the last region is done, the block presents a one-cycle certificate made of the device serial number, the digest, a user nonce and a failure status. Only on the cycle after that does it write the nonvolatile flag back to zero. A reset in the middle of a run does not lose the erase. When the block leaves reset it finds the flag still set and starts the run again from the first region, using the stored mode, with no new trigger.

Each region carries a class. The modes differ only in which classes they erase. The two permanently locked classes are never written, whatever the mode.

Top module: `zrz_ctrl`

## Requirements
- R1: A run starts from idle when `zeroize_pin` is high, or when `cmd_valid` is high with `cmd_code` equal to 8'hA5. A command with any other code is ignored.
- R2: The first action of a triggered run is one nonvolatile write with `nv_zip_d`=1 and `nv_mode_d` equal to the latched mode. No region write occurs while the stored flag reads 0.
- R3: For each selected region, the block first writes 0 to every word (`mem_we`, `mem_wdata`=0). It then reads every word (`mem_re`), and the data returns the following cycle. A region holds 8 words, so one clean pass is 8 writes.
- R4: Mode 0 (like new) erases only the user-data and user-key classes. With the default class map, region i has class i, so mode 0 erases regions 0 and 1.
- R5: Mode 1 (non-recoverable) erases every class except factory-lock (class 4) and user-permanent-lock (class 5). With the default map, that is regions 0 to 3. Regions of class 4 or 5 are never written.
- R6: When reset is released and `nv_zip_q` is 1, the block reruns the whole region walk from region 0 with the mode taken from `nv_mode_q`. It ignores `cfg_mode` and needs no trigger.
- R7: `cert_valid` pulses for one cycle after the last region. The certificate carries `dev_serial`, `user_nonce`, a failure flag and a digest. The digest starts at 16'h5A5A; for each checked word in read order it becomes rotate-left-by-1(digest) XOR read data.
- R8: The flag-clearing write (`nv_wr_en` with `nv_zip_d`=0) occurs exactly on the cycle after `cert_valid`, and at no other time.
- R9: While `suspend_cfg` is 1, triggers from both the pin and the command port are ignored.
- R10: `lockdown` neither blocks a run from starting nor aborts a run in progress.
- R11: Any nonzero word seen during verify sets a failure flag that stays set until the certificate. The region is then erased and verified once more. After that second pass it moves on, whatever the result.
- R12: `busy` is high from the commit cycle through the flag-clearing cycle. Triggers while busy do not start another run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zeroize_pin | input | 1 | Level trigger from a dedicated pin |
| cmd_valid | input | 1 | Command strobe from the debug/host port |
| cmd_code | input | 8 | Command code; 8'hA5 requests zeroization |
| suspend_cfg | input | 1 | Configuration bit that disables triggering |
| lockdown | input | 1 | Security lockdown indication (no effect on runs) |
| cfg_mode | input | 1 | Mode for a new run: 0 like new, 1 non-recoverable |
| dev_serial | input | 32 | Device serial number |
| user_nonce | input | 32 | Nonce placed in the certificate |
| nv_zip_q | input | 1 | Stored in-progress flag |
| nv_mode_q | input | 1 | Stored mode |
| nv_wr_en | output | 1 | Write strobe to the nonvolatile flag store |
| nv_zip_d | output | 1 | Flag value to store |
| nv_mode_d | output | 1 | Mode value to store |
| mem_region | output | 3 | Region index of the memory access |
| mem_addr | output | 3 | Word address within the region |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (always zero) |
| mem_re | output | 1 | Read strobe; data due next cycle |
| mem_rdata | input | 16 | Read-back data |
| busy | output | 1 | Run in progress |
| cert_valid | output | 1 | Certificate valid pulse |
| cert_serial | output | 32 | Certificate serial number |
| cert_nonce | output | 32 | Certificate nonce |
| cert_digest | output | 16 | Certificate digest |
| cert_fail | output | 1 | Certificate verify-failure status |

## Verification
The hardest situation to reach from the ports is a reset that lands partway through a region while the stored flag is set. The nonvolatile store in the bench model does not see `rst_n`. The stimulus watches the write strobe count into region 0, pulls reset after five writes and swaps `cfg_mode` before releasing it. The resumed run must then produce the certificate that the interrupted one was expected to give, using the stored mode. The second hard case is a verify mismatch that repeats on the retry pass. A read-fault injector in the memory model corrupts a chosen word for a set number of reads. This shows that the region gets exactly two passes and that the failure flag persists.

// File: rtl/zrz_pkg.sv
package zrz_pkg;

   typedef enum logic {
      ZM_LIKE_NEW  = 1'b0,
      ZM_NONRECOV  = 1'b1
   } zmode_e;

   localparam logic [2:0] RC_USER_DATA  = 3'd0;
   localparam logic [2:0] RC_USER_KEY   = 3'd1;
   localparam logic [2:0] RC_FACT_KEY   = 3'd2;
   localparam logic [2:0] RC_FACT_PARAM = 3'd3;
   localparam logic [2:0] RC_FACT_LOCK  = 3'd4;
   localparam logic [2:0] RC_USER_LOCK  = 3'd5;

   typedef enum logic [3:0] {
      S_BOOT, S_IDLE, S_COMMIT, S_FIND, S_WR,
      S_RD, S_CHK, S_REND, S_CERT, S_CLEAR
   } zstate_e;

endpackage

// File: rtl/zrz_trigger.sv
module zrz_trigger #(
   parameter logic [7:0] CMD_ZEROIZE = 8'hA5
) (
   input  logic       idle,
   input  logic       suspend_cfg,
   input  logic       zeroize_pin,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   output logic       start
);
   logic cmd_hit;

   assign cmd_hit = cmd_valid && (cmd_code == CMD_ZEROIZE);
   assign start   = idle && !suspend_cfg && (zeroize_pin || cmd_hit);

endmodule

// File: rtl/zrz_region_sel.sv
module zrz_region_sel
   import zrz_pkg::*;
#(
   parameter int                  N_REG        = 6,
   parameter logic [3*N_REG-1:0]  REGION_CLASS = 18'o543210
) (
   input  zmode_e           mode,
   output logic [N_REG-1:0] sel,
   output logic [N_REG-1:0] locked
);
   for (genvar g = 0; g < N_REG; g++) begin : g_reg
      localparam logic [2:0] CLS = REGION_CLASS[3*g +: 3];
      if (CLS == RC_USER_DATA || CLS == RC_USER_KEY) begin : g_user
         assign sel[g]    = 1'b1;
         assign locked[g] = 1'b0;
      end else if (CLS == RC_FACT_LOCK || CLS == RC_USER_LOCK) begin : g_lock
         assign sel[g]    = 1'b0;
         assign locked[g] = 1'b1;
      end else begin : g_other
         assign sel[g]    = (mode == ZM_NONRECOV);
         assign locked[g] = 1'b0;
      end
   end

endmodule

// File: rtl/zrz_digest.sv
module zrz_digest #(
   parameter int            DW   = 16,
   parameter logic [DW-1:0] SEED = 16'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] digest
);
   logic [DW-1:0] rot;

   assign rot = {digest[DW-2:0], digest[DW-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   digest <= SEED;
      else if (clr) digest <= SEED;
      else if (en)  digest <= rot ^ din;
   end

   assert_digest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(digest));

endmodule

// File: rtl/zrz_ctrl.sv
module zrz_ctrl
   import zrz_pkg::*;
#(
   parameter int                  N_REG        = 6,
   parameter int                  REGION_WORDS = 8,
   parameter int                  DW           = 16,
   parameter int                  SW           = 32,
   parameter int                  NW           = 32,
   parameter logic [7:0]          CMD_ZEROIZE  = 8'hA5,
   parameter logic [DW-1:0]       DIGEST_SEED  = 16'h5A5A,
   parameter logic [3*N_REG-1:0]  REGION_CLASS = 18'o543210,
   localparam int RW  = (N_REG > 1) ? $clog2(N_REG) : 1,
   localparam int RCW = $clog2(N_REG + 1),
   localparam int AW  = $clog2(REGION_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          zeroize_pin,
   input  logic          cmd_valid,
   input  logic [7:0]    cmd_code,
   input  logic          suspend_cfg,
   input  logic          lockdown,
   input  logic          cfg_mode,
   input  logic [SW-1:0] dev_serial,
   input  logic [NW-1:0] user_nonce,
   input  logic          nv_zip_q,
   input  logic          nv_mode_q,
   output logic          nv_wr_en,
   output logic          nv_zip_d,
   output logic          nv_mode_d,
   output logic [RW-1:0] mem_region,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          cert_valid,
   output logic [SW-1:0] cert_serial,
   output logic [NW-1:0] cert_nonce,
   output logic [DW-1:0] cert_digest,
   output logic          cert_fail
);
   localparam logic [RCW-1:0] END_R  = RCW'(N_REG);
   localparam logic [AW-1:0]  LAST_A = AW'(REGION_WORDS - 1);

   if (N_REG < 2)                     begin : g_bad_nreg  $error("N_REG must be at least 2");   end
   if (REGION_WORDS < 2)              begin : g_bad_words $error("REGION_WORDS must be >= 2");  end
   if ((1 << AW) != REGION_WORDS)     begin : g_bad_pow2  $error("REGION_WORDS must be 2^n");   end
   if (DW < 2)                        begin : g_bad_dw    $error("DW must be at least 2");      end

   zstate_e        state;
   zmode_e         mode_q;
   logic [RCW-1:0] rcnt;
   logic [AW-1:0]  addr;
   logic           bad;
   logic           retried;
   logic           fail;
   logic           start;
   logic [N_REG-1:0] sel;
   logic [N_REG-1:0] locked;
   logic           dig_clr;
   logic [DW-1:0]  digest;

   zrz_trigger #(.CMD_ZEROIZE(CMD_ZEROIZE)) u_trig (
      .idle        (state == S_IDLE),
      .suspend_cfg (suspend_cfg),
      .zeroize_pin (zeroize_pin),
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .start       (start)
   );

   zrz_region_sel #(.N_REG(N_REG), .REGION_CLASS(REGION_CLASS)) u_sel (
      .mode   (mode_q),
      .sel    (sel),
      .locked (locked)
   );

   assign dig_clr = ((state == S_IDLE) && start) || ((state == S_BOOT) && nv_zip_q);

   zrz_digest #(.DW(DW), .SEED(DIGEST_SEED)) u_dig (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (dig_clr),
      .en     (state == S_CHK),
      .din    (mem_rdata),
      .digest (digest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_BOOT;
         mode_q  <= ZM_LIKE_NEW;
         rcnt    <= '0;
         addr    <= '0;
         bad     <= 1'b0;
         retried <= 1'b0;
         fail    <= 1'b0;
      end else begin
         case (state)
            S_BOOT: begin
               if (nv_zip_q) begin
                  mode_q <= zmode_e'(nv_mode_q);
                  rcnt   <= '0;
                  fail   <= 1'b0;
                  state  <= S_FIND;
               end else begin
                  state  <= S_IDLE;
               end
            end
            S_IDLE: begin
               if (start) begin
                  mode_q <= zmode_e'(cfg_mode);
                  rcnt   <= '0;
                  fail   <= 1'b0;
                  state  <= S_COMMIT;
               end
            end
            S_COMMIT: state <= S_FIND;
            S_FIND: begin
               if (rcnt == END_R) begin
                  state <= S_CERT;
               end else if (sel[rcnt[RW-1:0]]) begin
                  addr    <= '0;
                  bad     <= 1'b0;
                  retried <= 1'b0;
                  state   <= S_WR;
               end else begin
                  rcnt <= rcnt + 1'b1;
               end
            end
            S_WR: begin
               if (addr == LAST_A) begin
                  addr  <= '0;
                  state <= S_RD;
               end else begin
                  addr <= addr + 1'b1;
               end
            end
            S_RD: state <= S_CHK;
            S_CHK: begin
               if (mem_rdata != '0) begin
                  bad  <= 1'b1;
                  fail <= 1'b1;
               end
               if (addr == LAST_A) begin
                  state <= S_REND;
               end else begin
                  addr  <= addr + 1'b1;
                  state <= S_RD;
               end
            end
            S_REND: begin
               if (bad && !retried) begin
                  retried <= 1'b1;
                  bad     <= 1'b0;
                  addr    <= '0;
                  state   <= S_WR;
               end else begin
                  rcnt  <= rcnt + 1'b1;
                  state <= S_FIND;
               end
            end
            S_CERT:  state <= S_CLEAR;
            S_CLEAR: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign nv_wr_en    = (state == S_COMMIT) || (state == S_CLEAR);
   assign nv_zip_d    = (state == S_COMMIT);
   assign nv_mode_d   = mode_q;
   assign mem_region  = rcnt[RW-1:0];
   assign mem_addr    = addr;
   assign mem_we      = (state == S_WR);
   assign mem_wdata   = '0;
   assign mem_re      = (state == S_RD);
   assign busy        = (state != S_IDLE) && (state != S_BOOT);
   assign cert_valid  = (state == S_CERT);
   assign cert_serial = dev_serial;
   assign cert_nonce  = user_nonce;
   assign cert_digest = digest;
   assign cert_fail   = fail;

   assert_commit_before_erase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> nv_zip_q);

   assert_no_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !locked[mem_region]);

   assert_clear_follows_cert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cert_valid |=> (nv_wr_en && !nv_zip_d));

   assert_clear_only_after_cert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_wr_en && !nv_zip_d) |-> $past(cert_valid));

   assert_suspend_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && suspend_cfg) |=> (state == S_IDLE));

   assert_lockdown_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lockdown && state != S_CLEAR) |=> busy);

   assert_single_retry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_REND && retried) |=> (state == S_FIND));

endmodule

// File: tb/zrz_ctrl_tb.sv
module zrz_ctrl_tb;
   localparam int N_REG = 6;
   localparam int WORDS = 8;

   typedef struct {
      logic [31:0] serial;
      logic [31:0] nonce;
      logic [15:0] dig;
      logic        fail;
   } cert_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        zeroize_pin = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = 8'h00;
   logic        suspend_cfg = 1'b0;
   logic        lockdown = 1'b0;
   logic        cfg_mode = 1'b0;
   logic [31:0] dev_serial = 32'hC0FF_EE01;
   logic [31:0] user_nonce = 32'h1234_5678;
   logic        nv_zip = 1'b0;
   logic        nv_mode = 1'b0;
   logic        nv_wr_en, nv_zip_d, nv_mode_d;
   logic [2:0]  mem_region, mem_addr;
   logic        mem_we, mem_re;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = 16'h0;
   logic        busy, cert_valid, cert_fail;
   logic [31:0] cert_serial, cert_nonce;
   logic [15:0] cert_digest;

   always #5 clk = ~clk;

   zrz_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .zeroize_pin(zeroize_pin), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .suspend_cfg(suspend_cfg), .lockdown(lockdown),
      .cfg_mode(cfg_mode), .dev_serial(dev_serial), .user_nonce(user_nonce),
      .nv_zip_q(nv_zip), .nv_mode_q(nv_mode), .nv_wr_en(nv_wr_en),
      .nv_zip_d(nv_zip_d), .nv_mode_d(nv_mode_d), .mem_region(mem_region),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .busy(busy), .cert_valid(cert_valid),
      .cert_serial(cert_serial), .cert_nonce(cert_nonce), .cert_digest(cert_digest),
      .cert_fail(cert_fail)
   );

   // nonvolatile flag store: untouched by rst_n
   always @(posedge clk) begin
      if (nv_wr_en) begin
         nv_zip  <= nv_zip_d;
         nv_mode <= nv_mode_d;
      end
   end

   // memory model with read-fault injector
   logic [15:0] mem [0:N_REG*WORDS-1] = '{default: 16'hFFFF};
   int          f_reg = -1, f_addr = 0, f_lim = 0;
   logic [15:0] f_val = 16'h0;
   int          f_used = 0;

   always @(posedge clk) begin
      if (mem_we) mem[int'(mem_region)*WORDS + int'(mem_addr)] <= mem_wdata;
      if (mem_re) begin
         if (f_used < f_lim && int'(mem_region) == f_reg && int'(mem_addr) == f_addr) begin
            mem_rdata <= f_val;
            f_used    <= f_used + 1;
         end else begin
            mem_rdata <= mem[int'(mem_region)*WORDS + int'(mem_addr)];
         end
      end
   end

   // scoreboard monitor
   cert_t exp_q[$];
   int    mon_chk = 0, mon_fail = 0;
   int    cyc = 0, last_cert = -10;
   int    wr_cnt [N_REG] = '{default: 0};

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (mem_we) begin
            wr_cnt[int'(mem_region)] <= wr_cnt[int'(mem_region)] + 1;
            mon_chk <= mon_chk + 1;
            if (!nv_zip) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R2: write with stored flag act=%0d exp=1", nv_zip);
            end else if (mem_wdata != 16'h0) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R3: write data act=%h exp=0000", mem_wdata);
            end
         end
         if (cert_valid) begin
            last_cert <= cyc;
            mon_chk <= mon_chk + 1;
            if (exp_q.size() == 0) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R12: unexpected certificate act=1 exp=0");
            end else begin
               cert_t e;
               e = exp_q.pop_front();
               if (cert_serial != e.serial || cert_nonce != e.nonce ||
                   cert_digest != e.dig || cert_fail != e.fail) begin
                  mon_fail <= mon_fail + 1;
                  $display("FAIL R7/R11: cert act=%h/%h/%h/%0d exp=%h/%h/%h/%0d",
                           cert_serial, cert_nonce, cert_digest, cert_fail,
                           e.serial, e.nonce, e.dig, e.fail);
               end
            end
         end
         if (nv_wr_en && !nv_zip_d) begin
            mon_chk <= mon_chk + 1;
            if (last_cert != cyc - 1) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R8: flag clear at cycle act=%0d exp=%0d", cyc, last_cert + 1);
            end
         end
      end
   end

   // driver side
   int drv_chk = 0, drv_fail = 0;
   int base [N_REG];

   task automatic dchk(input bit ok, input string tag, input int act, input int exp);
      drv_chk++;
      if (!ok) begin
         drv_fail++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic bit selected(input bit nr, input int r);
      return nr ? (r <= 3) : (r <= 1);
   endfunction

   task automatic expect_run(input bit nr, input int fr, input int fa,
                             input logic [15:0] fv, input int fcnt);
      cert_t e;
      logic [15:0] d;
      d = 16'h5A5A;
      for (int r = 0; r < N_REG; r++) begin
         if (!selected(nr, r)) continue;
         for (int p = 0; p < ((r == fr && fcnt > 0) ? 2 : 1); p++)
            for (int a = 0; a < WORDS; a++)
               d = {d[14:0], d[15]} ^ ((r == fr && a == fa && p < fcnt) ? fv : 16'h0);
      end
      e.serial = dev_serial;
      e.nonce  = user_nonce;
      e.dig    = d;
      e.fail   = (fcnt > 0) && selected(nr, fr);
      f_reg = fr; f_addr = fa; f_val = fv; f_lim = f_used + fcnt;
      exp_q.push_back(e);
   endtask

   task automatic snap();
      for (int r = 0; r < N_REG; r++) base[r] = wr_cnt[r];
   endtask

   task automatic check_writes(input string tag, input int e0, input int e1,
                               input int e2, input int e3);
      int ex [N_REG];
      ex = '{e0, e1, e2, e3, 0, 0};
      for (int r = 0; r < N_REG; r++)
         dchk(wr_cnt[r] - base[r] == ex[r], tag, wr_cnt[r] - base[r], ex[r]);
   endtask

   task automatic pulse_pin();
      @(negedge clk) zeroize_pin = 1'b1;
      @(negedge clk) zeroize_pin = 1'b0;
   endtask

   task automatic pulse_cmd(input logic [7:0] code);
      @(negedge clk) begin cmd_valid = 1'b1; cmd_code = code; end
      @(negedge clk) cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while ((exp_q.size() != 0 || busy) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
      dchk(n < 3000, tag, n, 0);
      dchk(nv_zip == 1'b0 && !busy, {tag, " flag cleared"}, nv_zip, 0);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               drv_chk + mon_chk + 1, drv_fail + mon_fail + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      dchk(!busy && !cert_valid && !nv_wr_en && !mem_we, "reset R12", busy, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      dchk(!busy && nv_zip == 1'b0, "boot idle R6", busy, 0);

      // like new via pin; a second trigger mid-run is ignored
      snap();
      cfg_mode = 1'b0;
      expect_run(1'b0, -1, 0, 16'h0, 0);
      pulse_pin();
      @(negedge clk);
      dchk(nv_zip == 1'b1 && nv_mode == 1'b0, "commit R2", nv_zip, 1);
      dchk(busy, "busy R12", busy, 1);
      repeat (10) @(negedge clk);
      pulse_pin();
      wait_done("like-new R1");
      check_writes("like-new writes R4", 8, 8, 0, 0);
      repeat (10) @(negedge clk);
      dchk(!busy && exp_q.size() == 0, "no rerun R12", busy, 0);

      // non-recoverable via command, single fault then clean retry
      snap();
      user_nonce = 32'hA0B1_C2D3;
      cfg_mode = 1'b1;
      pulse_cmd(8'h5A);
      repeat (4) @(negedge clk);
      dchk(!busy && nv_zip == 1'b0, "wrong code ignored R1", busy, 0);
      expect_run(1'b1, 2, 3, 16'h0040, 1);
      pulse_cmd(8'hA5);
      wait_done("nonrecov cmd R1");
      check_writes("nonrecov writes R5 R11", 8, 8, 16, 8);

      // suspend blocks both triggers
      suspend_cfg = 1'b1;
      pulse_pin();
      pulse_cmd(8'hA5);
      repeat (6) @(negedge clk);
      dchk(!busy && nv_zip == 1'b0, "suspend R9", busy, 0);
      suspend_cfg = 1'b0;

      // lockdown asserted, persistent fault: exactly one retry
      snap();
      lockdown = 1'b1;
      cfg_mode = 1'b1;
      expect_run(1'b1, 0, 7, 16'h8001, 2);
      pulse_pin();
      wait_done("lockdown R10");
      check_writes("persistent fault R11", 16, 8, 8, 8);
      lockdown = 1'b0;

      // reset mid-run: resume with stored mode
      cfg_mode = 1'b0;
      user_nonce = 32'h0BAD_F00D;
      snap();
      expect_run(1'b0, -1, 0, 16'h0, 0);
      pulse_pin();
      while (wr_cnt[0] - base[0] < 5) @(negedge clk);
      rst_n = 1'b0;
      cfg_mode = 1'b1;
      repeat (3) @(negedge clk);
      dchk(nv_zip == 1'b1, "flag survives reset R6", nv_zip, 1);
      snap();
      rst_n = 1'b1;
      wait_done("resume R6");
      check_writes("resume writes R6", 8, 8, 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               drv_chk + mon_chk, drv_fail + mon_fail);
      $finish;
   end

endmodule